// File: doc/BRIEF.md
# Sequential Convolution FIR Engine

This block evaluates a fixed-length FIR convolution, y(m) = sum over k from 0 to m of h(k)·x(m−k), using one multiplier that does one product per clock. Two index counters step through the sum in a triangle. The output index m selects the result being built. The tap index k sweeps from 0 up to m. The sample store is read at m−k and the coefficient store at k. Each product is added into an accumulator. When k catches up with m, the finished sum is presented on the output and the accumulator is cleared.

Before a run, software-side logic loads samples and coefficients through a single write port. It then pulses `start`. The engine emits one output per completed sum, marked by a one-cycle valid pulse. After the last output it stops and raises `done`. Operands are 8-bit two's complement. The multiplier works on magnitudes, and the product is negated when the operand signs differ. The 16-bit sum wraps without saturation.

Top module: `fir_conv_seq`

## Requirements
- R1: After reset, `outValid` is 0, `done` is 0 and `outData` is 0.
- R2: A run produces exactly NUM_POINTS (21) valid pulses, one for each m = 0..20 in increasing order. After that, no further pulse appears until the next start.
- R3: Output m takes m+1 product cycles. If `start` is captured at clock edge E, output 0 is valid after edge E+1 and output m is valid after edge E+(m+1)(m+2)/2.
- R4: Output m equals the sum over k=0..m of h[k]·x[m−k], taken modulo 2^16. x and h are the stored 8-bit two's-complement values.
- R5: Products of operands with differing signs are negative, and products of two negative operands are positive. This includes −128·−128 = +16384.
- R6: The accumulator starts from zero for every output. No partial sum carries from one output to the next, or from one run to the next.
- R7: `outValid` is high for single cycles only. `outData` holds its value between valid pulses.
- R8: `done` rises in the same cycle as the last valid pulse. It stays high until a new start is captured, and a captured start clears it.
- R9: Writes (`wrEn`=1, `wrSel`=0 selects the sample store, `wrSel`=1 the coefficient store, `wrAddr` = index) take effect only while no run is active. Writes during a run are ignored.
- R10: A `start` pulse during an active run is ignored and does not disturb output timing or values.
- R11: The accumulator wraps modulo 2^16. For example, with all operands at −128, output m equals ((m+1)·16384) mod 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| wrEn | input | 1 | Write strobe for the operand stores |
| wrSel | input | 1 | 0 = sample store, 1 = coefficient store |
| wrAddr | input | 5 | Store index, 0..20 |
| wrData | input | 8 | Two's-complement operand value |
| outValid | output | 1 | One-cycle pulse marking a finished output |
| outData | output | 16 | Finished convolution sum, two's complement |
| done | output | 1 | High from the last output until the next start |

## Verification
The bench builds the engine with its default parameters: 21 points, 8-bit operands and a 16-bit accumulator. With these values a full run reaches every counter value from 0 to 20, and the sum of magnitude products can exceed 2^16, so the wrap case occurs naturally. The directed data sets are an impulse, a set of mixed-sign values and a set with every operand at −128. Together they cover the negation path, including the largest magnitude. The timing of every valid pulse is compared against the triangular schedule. One run receives writes and a second `start` while it is active.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // strobes sent from sequencing control to the arithmetic datapath
  typedef struct packed {
    logic clear;  // new run accepted: zero the accumulator
    logic mac;    // a product is valid this cycle
    logic emit;   // this product completes the current output
  } fir_ctl_t;
endpackage

// File: rtl/fir_idx_counter.sv
module fir_idx_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rstN)    cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl #(
  parameter int NUM_POINTS = 21,
  parameter int IDX_W      = $clog2(NUM_POINTS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic [IDX_W-1:0]    outIdx,
  output logic [IDX_W-1:0]    tapIdx,
  output logic                running,
  output logic                done,
  output fir_pkg::fir_ctl_t   ctl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_POINTS - 1);

  logic startGo, idxMatch, lastOut, emitNow;

  assign startGo  = start && !running;
  assign idxMatch = (tapIdx == outIdx);
  assign lastOut  = (outIdx == LAST_IDX);
  assign emitNow  = running && idxMatch;

  fir_idx_counter #(.W(IDX_W)) u_outCnt (
    .clk (clk), .rstN(rstN),
    .clr (startGo),
    .inc (emitNow && !lastOut),
    .cnt (outIdx)
  );

  fir_idx_counter #(.W(IDX_W)) u_tapCnt (
    .clk (clk), .rstN(rstN),
    .clr (startGo || emitNow),
    .inc (running && !idxMatch),
    .cnt (tapIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      done    <= 1'b0;
    end else if (startGo) begin
      running <= 1'b1;
      done    <= 1'b0;
    end else if (emitNow && lastOut) begin
      running <= 1'b0;
      done    <= 1'b1;
    end
  end

  always_comb begin
    ctl.clear = startGo;
    ctl.mac   = running;
    ctl.emit  = emitNow;
  end

  // tap index never overtakes the output index (triangular sweep)
  p_tap_le_out_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (tapIdx <= outIdx));
  // output index stays inside the filter length
  p_out_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    outIdx <= LAST_IDX);
  // the run stops right after the last output
  p_stop_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    (emitNow && lastOut) |=> (!running && done));
  // done is held until a new start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath #(
  parameter int NUM_POINTS = 21,
  parameter int IDX_W      = $clog2(NUM_POINTS),
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fir_pkg::fir_ctl_t    ctl,
  input  logic                 running,
  input  logic [IDX_W-1:0]     outIdx,
  input  logic [IDX_W-1:0]     tapIdx,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [IDX_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 outValid,
  output logic [ACC_W-1:0]     outData
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] sampleMem [NUM_POINTS];
  logic [DATA_W-1:0] coefMem   [NUM_POINTS];
  logic              wrOk;

  assign wrOk = wrEn && !running &&
                ({1'b0, wrAddr} < (IDX_W+1)'(NUM_POINTS));

  for (genvar i = 0; i < NUM_POINTS; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sampleMem[i] <= '0;
        coefMem[i]   <= '0;
      end else if (wrOk && wrAddr == IDX_W'(i)) begin
        if (wrSel) coefMem[i]   <= wrData;
        else       sampleMem[i] <= wrData;
      end
    end
  end

  logic [IDX_W-1:0]  sampleAddr;
  logic [DATA_W-1:0] xVal, hVal, xMag, hMag;
  logic [PROD_W-1:0] magProd;
  logic [ACC_W-1:0]  prodExt, prodSigned, accReg, sumNext;
  logic              prodNeg;

  assign sampleAddr = outIdx - tapIdx;
  assign xVal       = sampleMem[sampleAddr];
  assign hVal       = coefMem[tapIdx];
  assign xMag       = xVal[DATA_W-1] ? (~xVal + 1'b1) : xVal;
  assign hMag       = hVal[DATA_W-1] ? (~hVal + 1'b1) : hVal;
  assign magProd    = PROD_W'(xMag) * PROD_W'(hMag);
  assign prodNeg    = xVal[DATA_W-1] ^ hVal[DATA_W-1];
  assign prodExt    = ACC_W'(magProd);
  assign prodSigned = prodNeg ? (~prodExt + 1'b1) : prodExt;
  assign sumNext    = accReg + prodSigned;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (ctl.clear) begin
        accReg <= '0;
      end else if (ctl.mac) begin
        if (ctl.emit) begin
          outData  <= sumNext;
          outValid <= 1'b1;
          accReg   <= '0;
        end else begin
          accReg <= sumNext;
        end
      end
    end
  end

  // valid is a single-cycle pulse
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // result register only moves on an emit strobe
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.emit |=> $stable(outData));
  // every output starts from an empty accumulator
  p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit || ctl.clear) |=> (accReg == '0));
endmodule

// File: rtl/fir_conv_seq.sv
module fir_conv_seq #(
  parameter int NUM_POINTS = 21,
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 16,
  localparam int IDX_W     = $clog2(NUM_POINTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              outValid,
  output logic [ACC_W-1:0]  outData,
  output logic              done
);
  fir_pkg::fir_ctl_t ctl;
  logic [IDX_W-1:0]  outIdx, tapIdx;
  logic              running;

  fir_ctrl #(.NUM_POINTS(NUM_POINTS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .outIdx(outIdx), .tapIdx(tapIdx),
    .running(running), .done(done), .ctl(ctl)
  );

  fir_datapath #(.NUM_POINTS(NUM_POINTS), .IDX_W(IDX_W),
                 .DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .running(running),
    .outIdx(outIdx), .tapIdx(tapIdx),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outData(outData)
  );

  // done rises together with the final valid pulse
  p_done_with_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> outValid);
endmodule

// File: tb/fir_conv_seq_tb.sv
module fir_conv_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPTS = 21;
  localparam int RUN_CYC = 260;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        outValid;
  logic [15:0] outData;
  logic        done;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;

  logic signed [7:0] xs [NPTS];
  logic signed [7:0] hs [NPTS];
  logic [15:0] gotY [64];
  int          gotT [64];
  int          gotCnt;
  int          doneT;

  fir_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outData(outData), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failCount = failCount + 1;
      testCount = testCount + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refY(input int m);
    int acc = 0;
    for (int k = 0; k <= m; k++) acc += int'(hs[k]) * int'(xs[m-k]);
    return acc[15:0];
  endfunction

  task automatic writeWord(input bit sel, input int addr, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = 5'(addr); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadAll();
    for (int i = 0; i < NPTS; i++) begin
      writeWord(1'b0, i, xs[i]);
      writeWord(1'b1, i, hs[i]);
    end
  endtask

  // pulse start, then watch RUN_CYC cycles; optional writes and start during the run
  task automatic runFilter(input bit disturb);
    gotCnt = 0; doneT = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 1; c <= RUN_CYC; c++) begin
      if (disturb && c >= 5 && c <= 8) begin
        wrEn = 1'b1; wrSel = c[0]; wrAddr = 5'(c - 5); wrData = 8'h5A;
      end else begin
        wrEn = 1'b0;
      end
      start = (disturb && c == 10);
      @(negedge clk);
      if (outValid && gotCnt < 64) begin
        gotY[gotCnt] = outData; gotT[gotCnt] = c; gotCnt++;
      end
      if (done && doneT < 0) doneT = c;
    end
    wrEn = 1'b0; start = 1'b0;
  endtask

  task automatic checkRun(input string tag);
    check(gotCnt == NPTS, {tag, " R2 output count"}, gotCnt, NPTS);
    for (int m = 0; m < NPTS && m < gotCnt; m++) begin
      check(gotY[m] == refY(m), {tag, " R4 value"}, int'(gotY[m]), int'(refY(m)));
      check(gotT[m] == (m+1)*(m+2)/2, {tag, " R3 timing"}, gotT[m], (m+1)*(m+2)/2);
    end
    check(doneT == NPTS*(NPTS+1)/2, {tag, " R8 done timing"}, doneT, NPTS*(NPTS+1)/2);
    check(done == 1'b1, {tag, " R8 done held"}, int'(done), 1);
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(outData == 16'h0, "R1 outData", int'(outData), 0);
  endtask

  task automatic testImpulse();
    for (int i = 0; i < NPTS; i++) begin
      xs[i] = (i == 0) ? 8'sd1 : 8'sd0;
      hs[i] = 8'(i*3 - 30);
    end
    loadAll();
    runFilter(1'b0);
    checkRun("impulse R4");
  endtask

  task automatic testMixedSigns();
    for (int i = 0; i < NPTS; i++) begin
      xs[i] = 8'((i*37 + 11) % 256);
      hs[i] = 8'((i*53 + 200) % 256);
    end
    xs[2] = -8'sd128; hs[0] = -8'sd128;
    loadAll();
    runFilter(1'b0);
    checkRun("mixed R5 R6");
    // second run on the same data: no carry-over between runs
    runFilter(1'b0);
    checkRun("rerun R6");
  endtask

  task automatic testWrap();
    for (int i = 0; i < NPTS; i++) begin xs[i] = -8'sd128; hs[i] = -8'sd128; end
    loadAll();
    runFilter(1'b0);
    checkRun("wrap R11");
    if (gotCnt > 3) check(gotY[3] == 16'h0000, "R11 four products wrap to 0", int'(gotY[3]), 0);
    if (gotCnt > 0) check(gotY[0] == 16'h4000, "R5 neg times neg", int'(gotY[0]), 16384);
  endtask

  task automatic testDisturb();
    for (int i = 0; i < NPTS; i++) begin
      xs[i] = 8'(i + 1); hs[i] = 8'(7 - i);
    end
    loadAll();
    runFilter(1'b1);
    checkRun("disturb R9 R10");
    runFilter(1'b0);
    checkRun("after disturb R9");
  endtask

  task automatic testDoneClear();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R8 start clears done", int'(done), 1'b0);
    repeat (RUN_CYC) @(negedge clk);
    check(done == 1'b1, "R8 done after run", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testImpulse();
    testMixedSigns();
    testWrap();
    testDisturb();
    testDoneClear();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule